// File: doc/BRIEF.md
# Lockable Two-Stage Watchdog Timer

This peripheral watches over software with a 32-bit down-counter. Software programs a reload value and enables counting. When the count first runs out, the block raises an interrupt and starts again from the reload value. If software has still not acknowledged that interrupt when the count runs out a second time, the block asserts a reset request, provided resets are enabled. The reset request stays high until the block's own reset input is applied.

The registers sit on a simple APB-style bus, where a setup phase is followed by an access phase. A lock register protects the configuration. A single magic value written to it opens the block. Any other value written to it closes the block again. While the block is closed, writes to every other register are dropped.

Top module: `wdog_twostage`

## Requirements
- R1: After reset the block is unlocked and stopped. The reload value and the count both read 0xFFFFFFFF. The control register reads 0, and `irq_o` and `rst_req_o` are low.
- R2: Writing 0x1ACCE551 to the lock register (offset 0xC00) unlocks the block, and writing any other value locks it. Reading offset 0xC00 returns 1 when the block is locked and 0 when it is unlocked.
- R3: While the block is locked, writes to the reload (0x00), control (0x08) and acknowledge (0x0C) registers have no effect.
- R4: A write to the reload register (0x00) loads the count with the new value in the same cycle. The count is read at offset 0x04, and writes to that offset are ignored.
- R5: With counting enabled and reload value L, the count steps down once per cycle. On the cycle after it reaches 0 it raises the pending interrupt and reloads L, so the first interrupt appears L+1 cycles after the enabling write.
- R6: If the count expires while the interrupt is pending and reset-enable (control bit 1) is set, `rst_req_o` goes high. It stays high until `rst` is applied, whatever is written over the bus.
- R7: If reset-enable is clear, a second expiry with the interrupt pending leaves `rst_req_o` low and keeps the interrupt pending.
- R8: Any write to offset 0x0C clears the pending interrupt and reloads the count from the reload register.
- R9: Setting the enable bit (control bit 0) from clear starts counting from the reload value. Clearing it freezes the count at its current value.
- R10: Offset 0x10 reads the pending (raw) interrupt in bit 0. Offset 0x14 reads that bit ANDed with the enable bit, and this masked value is what `irq_o` shows. Control reads back enable in bit 0 and reset-enable in bit 1.
- R11: Read data is captured at the end of the setup phase and held on `prdata` through the access phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 12 | Byte offset of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| irq_o | output | 1 | Masked interrupt |
| rst_req_o | output | 1 | Sticky reset request |

## Verification
The bench times the first and second expiries to the exact cycle. A counter that reloads one cycle early or late, or that resumes from its frozen value instead of the reload value, moves the edge and is caught. It checks that an acknowledge given between expiries prevents the reset request. A design that only clears the flag without reloading, or that ignores the acknowledge, would then reset or fire early. It writes a near-miss code to the lock register and then tries each protected register, which exposes a loose key compare or a lock that guards only some of the registers. It also confirms that the reset request survives bus writes and that no reset request appears when reset-enable is clear.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int OFS_RELOAD = 'h000;
  localparam int OFS_COUNT  = 'h004;
  localparam int OFS_CTRL   = 'h008;
  localparam int OFS_ACK    = 'h00C;
  localparam int OFS_RAW    = 'h010;
  localparam int OFS_MASKED = 'h014;
  localparam int OFS_LOCK   = 'hC00;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_RST_BIT = 1;

  typedef struct packed {
    logic reload;
    logic ctrl;
    logic ack;
    logic start;
  } wdog_evt_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter int          ADDR_W     = 12,
  parameter logic [31:0] UNLOCK_KEY = 32'h1ACC_E551,
  parameter logic [31:0] RELOAD_RST = 32'hFFFF_FFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] reload_o,
  output logic              en_o,
  output logic              rsten_o,
  output logic              locked_o,
  output wdog_evt_t         evt_o
);
  logic wr_cycle;
  logic wr_open;
  logic hit_reload, hit_ctrl, hit_ack, hit_lock;

  logic [DATA_W-1:0] reload_q;
  logic              en_q, rsten_q, locked_q;

  assign wr_cycle   = psel & penable & pwrite;
  assign wr_open    = wr_cycle & ~locked_q;
  assign hit_reload = (paddr == ADDR_W'(OFS_RELOAD));
  assign hit_ctrl   = (paddr == ADDR_W'(OFS_CTRL));
  assign hit_ack    = (paddr == ADDR_W'(OFS_ACK));
  assign hit_lock   = (paddr == ADDR_W'(OFS_LOCK));

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= DATA_W'(RELOAD_RST);
      en_q     <= 1'b0;
      rsten_q  <= 1'b0;
      locked_q <= 1'b0;
    end else begin
      if (wr_cycle && hit_lock)
        locked_q <= (pwdata != DATA_W'(UNLOCK_KEY));
      if (wr_open && hit_reload)
        reload_q <= pwdata;
      if (wr_open && hit_ctrl) begin
        en_q    <= pwdata[CTRL_EN_BIT];
        rsten_q <= pwdata[CTRL_RST_BIT];
      end
    end
  end

  always_comb begin
    evt_o.reload = wr_open & hit_reload;
    evt_o.ctrl   = wr_open & hit_ctrl;
    evt_o.ack    = wr_open & hit_ack;
    evt_o.start  = wr_open & hit_ctrl & pwdata[CTRL_EN_BIT] & ~en_q;
  end

  assign reload_o = reload_q;
  assign en_o     = en_q;
  assign rsten_o  = rsten_q;
  assign locked_o = locked_q;
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter logic [31:0] RELOAD_RST = 32'hFFFF_FFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              rsten_i,
  input  logic [DATA_W-1:0] reload_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  wdog_evt_t         evt_i,
  output logic [DATA_W-1:0] count_o,
  output logic              raw_o,
  output logic              rst_req_o
);
  logic [DATA_W-1:0] count_q;
  logic              raw_q, rst_req_q;
  logic              bus_touch;
  logic              expire;

  assign bus_touch = evt_i.reload | evt_i.ack | evt_i.start;
  assign expire    = en_i & (count_q == '0) & ~bus_touch;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q   <= DATA_W'(RELOAD_RST);
      raw_q     <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      if (evt_i.reload)
        count_q <= wdata_i;
      else if (evt_i.ack || evt_i.start)
        count_q <= reload_i;
      else if (expire)
        count_q <= reload_i;
      else if (en_i)
        count_q <= count_q - 1'b1;

      if (evt_i.ack)
        raw_q <= 1'b0;
      else if (expire)
        raw_q <= 1'b1;

      if (expire && raw_q && rsten_i)
        rst_req_q <= 1'b1;
    end
  end

  assign count_o   = count_q;
  assign raw_o     = raw_q;
  assign rst_req_o = rst_req_q;
endmodule

// File: rtl/wdog_rdmux.sv
module wdog_rdmux
  import wdog_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] reload_i,
  input  logic [DATA_W-1:0] count_i,
  input  logic              en_i,
  input  logic              rsten_i,
  input  logic              raw_i,
  input  logic              locked_i,
  output logic [DATA_W-1:0] prdata_o
);
  logic [DATA_W-1:0] sel_data;
  logic [DATA_W-1:0] ctrl_word;

  always_comb begin
    ctrl_word               = '0;
    ctrl_word[CTRL_EN_BIT]  = en_i;
    ctrl_word[CTRL_RST_BIT] = rsten_i;
  end

  always_comb begin
    sel_data = '0;
    if (paddr == ADDR_W'(OFS_RELOAD))      sel_data = reload_i;
    else if (paddr == ADDR_W'(OFS_COUNT))  sel_data = count_i;
    else if (paddr == ADDR_W'(OFS_CTRL))   sel_data = ctrl_word;
    else if (paddr == ADDR_W'(OFS_RAW))    sel_data = DATA_W'(raw_i);
    else if (paddr == ADDR_W'(OFS_MASKED)) sel_data = DATA_W'(raw_i & en_i);
    else if (paddr == ADDR_W'(OFS_LOCK))   sel_data = DATA_W'(locked_i);
  end

  always_ff @(posedge clk) begin
    if (rst)
      prdata_o <= '0;
    else if (psel && !penable && !pwrite)
      prdata_o <= sel_data;
  end
endmodule

// File: rtl/wdog_twostage.sv
module wdog_twostage
  import wdog_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter int          ADDR_W     = 12,
  parameter logic [31:0] UNLOCK_KEY = 32'h1ACC_E551,
  parameter logic [31:0] RELOAD_RST = 32'hFFFF_FFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              irq_o,
  output logic              rst_req_o
);
  logic [DATA_W-1:0] reload_w;
  logic [DATA_W-1:0] count_w;
  logic              en_w, rsten_w, locked_w, raw_w;
  wdog_evt_t         evt_w;

  wdog_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .UNLOCK_KEY(UNLOCK_KEY), .RELOAD_RST(RELOAD_RST)
  ) u_regs (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .reload_o(reload_w), .en_o(en_w),
    .rsten_o(rsten_w), .locked_o(locked_w), .evt_o(evt_w)
  );

  wdog_core #(
    .DATA_W(DATA_W), .RELOAD_RST(RELOAD_RST)
  ) u_core (
    .clk(clk), .rst(rst), .en_i(en_w), .rsten_i(rsten_w),
    .reload_i(reload_w), .wdata_i(pwdata), .evt_i(evt_w),
    .count_o(count_w), .raw_o(raw_w), .rst_req_o(rst_req_o)
  );

  wdog_rdmux #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_rdmux (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .reload_i(reload_w), .count_i(count_w), .en_i(en_w),
    .rsten_i(rsten_w), .raw_i(raw_w), .locked_i(locked_w), .prdata_o(prdata)
  );

  assign irq_o = raw_w & en_w;
endmodule

// File: rtl/wdog_checks.sv
module wdog_checks
  import wdog_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter int          ADDR_W     = 12,
  parameter logic [31:0] UNLOCK_KEY = 32'h1ACC_E551
) (
  input logic              clk,
  input logic              rst,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [DATA_W-1:0] pwdata,
  input logic              rst_req_o,
  input logic              locked,
  input logic [DATA_W-1:0] reload,
  input logic [DATA_W-1:0] count,
  input logic              en,
  input logic              rsten,
  input logic              raw
);
  logic wr_any;
  assign wr_any = psel & penable & pwrite;

  assert_key_opens_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_any && paddr == ADDR_W'(OFS_LOCK) && pwdata == DATA_W'(UNLOCK_KEY)) |=> !locked);

  assert_other_closes_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_any && paddr == ADDR_W'(OFS_LOCK) && pwdata != DATA_W'(UNLOCK_KEY)) |=> locked);

  assert_locked_reload_R3: assert property (@(posedge clk) disable iff (rst)
    (locked && wr_any && paddr == ADDR_W'(OFS_RELOAD)) |=> $stable(reload));

  assert_locked_ctrl_R3: assert property (@(posedge clk) disable iff (rst)
    (locked && wr_any && paddr == ADDR_W'(OFS_CTRL)) |=> ($stable(en) && $stable(rsten)));

  assert_irq_from_zero_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(raw) |-> $past(en && count == '0));

  assert_rst_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |=> rst_req_o);

  assert_rst_cause_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_req_o) |-> $past(raw && rsten && en));

  assert_no_rst_disabled_R7: assert property (@(posedge clk) disable iff (rst)
    (!rsten && !rst_req_o) |=> !rst_req_o);

  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_any && !locked && paddr == ADDR_W'(OFS_ACK)) |=> !raw);

  assert_stopped_holds_R9: assert property (@(posedge clk) disable iff (rst)
    (!en && !wr_any) |=> $stable(count));
endmodule

bind wdog_twostage wdog_checks #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .UNLOCK_KEY(UNLOCK_KEY)
) u_checks (
  .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .rst_req_o(rst_req_o), .locked(locked_w),
  .reload(reload_w), .count(count_w), .en(en_w), .rsten(rsten_w), .raw(raw_w)
);

// File: tb/tb_wdog_twostage.sv
module tb_wdog_twostage;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] KEY = 32'h1ACC_E551;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        irq_o, rst_req_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic rd_valid = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  wdog_twostage dut (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq_o(irq_o),
    .rst_req_o(rst_req_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  // monitor: pops one expected read per completed access phase
  initial begin
    forever begin
      @(posedge rd_valid);
      if (exp_q.size() == 0) begin
        check("scoreboard-empty", 32'd1, 32'd0);
      end else begin
        check(tag_q.pop_front(), prdata, exp_q.pop_front());
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(logic [11:0] a, logic [31:0] d);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk); penable = 1'b1;
    @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic bus_read(logic [11:0] a, logic [31:0] exp, string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk); penable = 1'b1;
    #1 rd_valid = 1'b1;
    @(negedge clk); psel = 1'b0; penable = 1'b0; rd_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    idle(3);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired got=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    check("R1 irq after reset", irq_o, 0);
    check("R1 rst_req after reset", rst_req_o, 0);
    bus_read(12'h000, 32'hFFFF_FFFF, "R1 reload reset");
    bus_read(12'h004, 32'hFFFF_FFFF, "R1 count reset");
    bus_read(12'h008, 32'h0, "R1 ctrl reset");
    bus_read(12'hC00, 32'h0, "R2 unlocked after reset");

    // R4 reload write reloads count; R11 read via access phase
    bus_write(12'h000, 32'd5);
    bus_read(12'h004, 32'd5, "R4 count reloaded");
    bus_read(12'h000, 32'd5, "R11 reload readback");

    // R5/R6 two-stage expiry with reset enabled
    bus_write(12'h008, 32'h3);
    idle(5);
    check("R5 no irq before expiry", irq_o, 0);
    idle(1);
    check("R5 irq at first expiry", irq_o, 1);
    idle(5);
    check("R6 no reset before second expiry", rst_req_o, 0);
    idle(1);
    check("R6 reset at second expiry", rst_req_o, 1);
    bus_read(12'h008, 32'h3, "R10 ctrl bits");
    bus_read(12'h010, 32'h1, "R10 raw status");
    bus_read(12'h014, 32'h1, "R10 masked status");
    idle(20);
    bus_write(12'h00C, 32'h0);
    bus_write(12'h008, 32'h0);
    check("R6 reset sticky over bus writes", rst_req_o, 1);
    do_reset();
    check("R6 reset cleared by rst", rst_req_o, 0);

    // R8 acknowledge between expiries prevents reset
    bus_write(12'h000, 32'd5);
    bus_write(12'h008, 32'h3);
    idle(6);
    check("R8 irq before ack", irq_o, 1);
    bus_write(12'h00C, 32'hDEAD_BEEF);
    check("R8 irq cleared by ack", irq_o, 0);
    idle(5);
    check("R8 count reloaded by ack", irq_o, 0);
    idle(1);
    check("R8 irq again after reload", irq_o, 1);
    check("R8 no reset after ack", rst_req_o, 0);

    // R7 reset-enable clear
    do_reset();
    bus_write(12'h000, 32'd3);
    bus_write(12'h008, 32'h1);
    idle(4);
    check("R7 first irq", irq_o, 1);
    idle(4);
    check("R7 no reset with rsten clear", rst_req_o, 0);
    check("R7 irq still pending", irq_o, 1);
    bus_write(12'h008, 32'h0);
    check("R10 irq_o masked by enable", irq_o, 0);
    bus_read(12'h010, 32'h1, "R10 raw kept when disabled");
    bus_read(12'h014, 32'h0, "R10 masked zero when disabled");

    // R9 stop freezes, restart from reload
    do_reset();
    bus_write(12'h000, 32'd10);
    bus_write(12'h008, 32'h1);
    idle(3);
    bus_write(12'h008, 32'h0);
    bus_read(12'h004, 32'd5, "R9 count frozen");
    bus_read(12'h004, 32'd5, "R9 count still frozen");
    bus_write(12'h008, 32'h1);
    idle(10);
    check("R9 restart from reload no early irq", irq_o, 0);
    idle(1);
    check("R9 restart irq on time", irq_o, 1);

    // R2/R3 lock
    bus_write(12'h008, 32'h0);
    bus_write(12'hC00, KEY ^ 32'h1);
    bus_read(12'hC00, 32'h1, "R2 near-miss code locks");
    bus_write(12'h000, 32'd7);
    bus_read(12'h000, 32'd10, "R3 reload write ignored");
    bus_write(12'h008, 32'h3);
    bus_read(12'h008, 32'h0, "R3 ctrl write ignored");
    check("R3 irq stays masked", irq_o, 0);
    bus_write(12'h00C, 32'h0);
    bus_read(12'h010, 32'h1, "R3 ack write ignored");
    bus_write(12'hC00, KEY);
    bus_read(12'hC00, 32'h0, "R2 key unlocks");
    bus_write(12'h000, 32'd7);
    bus_read(12'h000, 32'd7, "R4 reload write accepted");
    bus_read(12'h004, 32'd7, "R4 count follows reload write");
    bus_write(12'h004, 32'd99);
    bus_read(12'h004, 32'd7, "R4 count is read-only");
    bus_write(12'h00C, 32'h0);
    bus_read(12'h010, 32'h0, "R8 ack clears raw");

    idle(2);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule